// File: doc/BRIEF.md
# Shared Timer Event Interrupt Merger

This block folds eight per-channel timer event requests into one shared interrupt request. Every channel owns a sticky pending bit that a single-cycle event pulse from its capture or compare logic sets. Each channel also has an enable bit in a mask register. The shared request is raised only when the OR of the enabled pending bits changes from zero to one. A pending bit that stays set, or a further event on an already-active group, does not raise the shared request again. Software can re-trigger it by dropping the whole mask to zero and then restoring it.

Software reaches two registers through a write strobe, a one-bit register select and a data bus. Select 0 is the pending register. A write to it clears every bit written as 0 and leaves every bit written as 1 unchanged. Select 1 is the mask register, which a write loads in full. The shared request is cleared by a separate acknowledge input.

A timer clock enable strobe, running inside the system clock domain, defines a clear-inhibit window. After a pending bit is set, software clears of that bit are ignored up to and including the first strobe cycle.

Top module: `evt_irq_merger`

## Requirements
- R1: After reset, `pend_q`, `mask_q` and `irq` are all zero.
- R2: An `evt[i]` pulse sets `pend_q[i]` at the next clock edge, whether or not `mask_q[i]` is 1.
- R3: A set `pend_q[i]` stays 1 until a write with `wr_sel`=0 carries 0 in bit i. In such a write, bits given as 1 keep their value.
- R4: After `evt[i]`, a clear of bit i is ignored from the next cycle through the first cycle with `tick`=1, inclusive. An event that coincides with `tick` still opens a fresh window.
- R5: When `evt[i]` and a clear of bit i fall in the same cycle, `pend_q[i]` is 1 afterwards.
- R6: A write with `wr_sel`=1 loads `wr_data` into `mask_q` at the next edge.
- R7: When the OR of `pend_q & mask_q` goes from 0 to 1, `irq` becomes 1 one cycle later. This is two edges after the event pulse.
- R8: `irq` stays 1 until an `ack` cycle without a new rise, and it is 0 after that cycle.
- R9: While the masked OR stays 1, further events and pending bits do not set `irq` again after it has been acknowledged.
- R10: Pending bits of channels whose mask bit is 0 never cause `irq`.
- R11: If `ack` and a new rise of the masked OR fall in the same cycle, `irq` is 1 afterwards.
- R12: Writing 00h to the mask and then restoring a mask that covers a pending bit raises `irq` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock enable strobe, one cycle wide |
| evt | input | NCH | Per-channel event pulses |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the pending register, 1 selects the mask register |
| wr_data | input | NCH | Write data |
| ack | input | 1 | Clears the shared request |
| pend_q | output | NCH | Pending bits |
| mask_q | output | NCH | Channel enable mask |
| irq | output | 1 | Shared interrupt request |

## Verification
Two pairs of functions can collide in one cycle.

- **Event against clear.** A channel event and a software clear of the same bit are driven in the same vector. The pending register is then checked to still hold the bit.
- **Rise against acknowledge.** The mask is dropped and restored so that the masked OR rises in the very cycle that `ack` is high. The shared request is judged as set one edge later.

The clear-inhibit window is also crossed with `tick` arriving in the event's own cycle. A clear issued before the next strobe must be ignored.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  typedef enum logic {SEL_PEND = 1'b0, SEL_MASK = 1'b1} reg_sel_e;

  // masked OR of pending and enabled channels
  function automatic logic masked_any(input logic [31:0] pend, input logic [31:0] mask);
    return |(pend & mask);
  endfunction

  // a written 0 requests a clear of that bit
  function automatic logic [31:0] clear_req(input logic [31:0] wdata);
    return ~wdata;
  endfunction

  // shared flag next state: a new rise has priority over acknowledge
  function automatic logic flag_next(input logic cur, input logic rise, input logic ack);
    return rise | (cur & ~ack);
  endfunction

endpackage

// File: rtl/evt_pend_bank.sv
module evt_pend_bank #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [NCH-1:0] evt,
  input  logic [NCH-1:0] clr,
  output logic [NCH-1:0] pend,
  output logic [NCH-1:0] lock
);
  // one sticky bit and one inhibit flag per channel
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic p_q, l_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        p_q <= 1'b0;
        l_q <= 1'b0;
      end else begin
        if (evt[g])                 p_q <= 1'b1;
        else if (clr[g] && !l_q)    p_q <= 1'b0;
        if (evt[g])                 l_q <= 1'b1;
        else if (tick)              l_q <= 1'b0;
      end
    end
    assign pend[g] = p_q;
    assign lock[g] = l_q;
  end
endmodule

// File: rtl/evt_mask_reg.sv
module evt_mask_reg #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [NCH-1:0] din,
  output logic [NCH-1:0] mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask <= '0;
    else if (load) mask <= din;
  end
endmodule

// File: rtl/evt_edge_flag.sv
module evt_edge_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic any_now,
  input  logic ack,
  output logic rise,
  output logic flag
);
  import evt_irq_pkg::*;
  logic any_dly;

  assign rise = any_now & ~any_dly;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_dly <= 1'b0;
      flag    <= 1'b0;
    end else begin
      any_dly <= any_now;
      flag    <= flag_next(flag, rise, ack);
    end
  end
endmodule

// File: rtl/evt_irq_merger.sv
module evt_irq_merger #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [NCH-1:0] evt,
  input  logic           wr_en,
  input  logic           wr_sel,
  input  logic [NCH-1:0] wr_data,
  input  logic           ack,
  output logic [NCH-1:0] pend_q,
  output logic [NCH-1:0] mask_q,
  output logic           irq
);
  import evt_irq_pkg::*;
  localparam int PADW = 32 - NCH;

  // named internal events, used by the checker
  logic           pend_wr;
  logic           mask_wr;
  logic [NCH-1:0] clr_w;
  logic [NCH-1:0] lock_q;
  logic           any_w;
  logic           rise_w;
  logic [31:0]    clr_full;

  assign pend_wr  = wr_en && (reg_sel_e'(wr_sel) == SEL_PEND);
  assign mask_wr  = wr_en && (reg_sel_e'(wr_sel) == SEL_MASK);
  assign clr_full = clear_req({{PADW{1'b1}}, wr_data});
  assign clr_w    = pend_wr ? clr_full[NCH-1:0] : '0;
  assign any_w    = masked_any({{PADW{1'b0}}, pend_q}, {{PADW{1'b0}}, mask_q});

  evt_pend_bank #(.NCH(NCH)) u_bank (
    .clk(clk), .rst_n(rst_n), .tick(tick), .evt(evt),
    .clr(clr_w), .pend(pend_q), .lock(lock_q)
  );

  evt_mask_reg #(.NCH(NCH)) u_mask (
    .clk(clk), .rst_n(rst_n), .load(mask_wr), .din(wr_data), .mask(mask_q)
  );

  evt_edge_flag u_edge (
    .clk(clk), .rst_n(rst_n), .any_now(any_w), .ack(ack),
    .rise(rise_w), .flag(irq)
  );
endmodule

// File: rtl/evt_irq_merger_chk.sv
module evt_irq_merger_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] evt,
  input logic           wr_en,
  input logic           wr_sel,
  input logic [NCH-1:0] wr_data,
  input logic           ack,
  input logic [NCH-1:0] pend_q,
  input logic [NCH-1:0] mask_q,
  input logic           irq,
  input logic [NCH-1:0] lock_q,
  input logic           rise_w
);
  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((pend_q & $past(evt)) == $past(evt)));

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !wr_sel) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  assert_inhibit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=>
      ((pend_q & $past(pend_q & lock_q)) == $past(pend_q & lock_q)));

  assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (mask_q == $past(wr_data)));

  assert_set_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(rise_w));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> irq);

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !rise_w) |=> !irq);

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rise_w |=> irq);
endmodule

bind evt_irq_merger evt_irq_merger_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .ack(ack), .pend_q(pend_q), .mask_q(mask_q),
  .irq(irq), .lock_q(lock_q), .rise_w(rise_w)
);

// File: tb/test_evt_irq_merger.sv
module test_evt_irq_merger;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] evt = '0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       ack = 1'b0;
  logic [7:0] pend_q, mask_q;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  evt_irq_merger #(.NCH(8)) i_evt_irq_merger (
    .clk(clk), .rst_n(rst_n), .tick(tick), .evt(evt), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .ack(ack),
    .pend_q(pend_q), .mask_q(mask_q), .irq(irq)
  );

  // {tag, evt, we, sel, data, ack, tick, exp_pend, exp_mask, exp_irq}
  localparam int NV = 33;
  localparam logic [40:0] VEC [NV] = '{
    {4'd6,  8'h00,1'b1,1'b1,8'h05,1'b0,1'b0, 8'h00,8'h05,1'b0}, // R6 mask load
    {4'd2,  8'h01,1'b0,1'b0,8'h00,1'b0,1'b0, 8'h01,8'h05,1'b0}, // R2 event sets
    {4'd7,  8'h00,1'b0,1'b0,8'h00,1'b0,1'b0, 8'h01,8'h05,1'b1}, // R7 irq rises
    {4'd8,  8'h00,1'b0,1'b0,8'h00,1'b0,1'b0, 8'h01,8'h05,1'b1}, // R8 hold
    {4'd8,  8'h00,1'b0,1'b0,8'h00,1'b1,1'b0, 8'h01,8'h05,1'b0}, // R8 ack
    {4'd4,  8'h00,1'b1,1'b0,8'hFE,1'b0,1'b0, 8'h01,8'h05,1'b0}, // R4 clear blocked
    {4'd4,  8'h00,1'b0,1'b0,8'h00,1'b0,1'b1, 8'h01,8'h05,1'b0}, // R4 tick ends window
    {4'd3,  8'h00,1'b1,1'b0,8'hFE,1'b0,1'b0, 8'h00,8'h05,1'b0}, // R3 clear by 0
    {4'd2,  8'h02,1'b0,1'b0,8'h00,1'b0,1'b0, 8'h02,8'h05,1'b0}, // R2 masked chan records
    {4'd10, 8'h00,1'b0,1'b0,8'h00,1'b0,1'b0, 8'h02,8'h05,1'b0}, // R10 no irq
    {4'd2,  8'h04,1'b0,1'b0,8'h00,1'b0,1'b0, 8'h06,8'h05,1'b0}, // R2
    {4'd7,  8'h00,1'b0,1'b0,8'h00,1'b0,1'b0, 8'h06,8'h05,1'b1}, // R7
    {4'd8,  8'h00,1'b0,1'b0,8'h00,1'b1,1'b0, 8'h06,8'h05,1'b0}, // R8
    {4'd9,  8'h01,1'b0,1'b0,8'h00,1'b0,1'b0, 8'h07,8'h05,1'b0}, // R9 new event
    {4'd9,  8'h00,1'b0,1'b0,8'h00,1'b0,1'b0, 8'h07,8'h05,1'b0}, // R9 no re-raise
    {4'd6,  8'h00,1'b1,1'b1,8'h00,1'b0,1'b0, 8'h07,8'h00,1'b0}, // R6 mask off
    {4'd12, 8'h00,1'b0,1'b0,8'h00,1'b0,1'b0, 8'h07,8'h00,1'b0}, // R12
    {4'd12, 8'h00,1'b1,1'b1,8'h05,1'b0,1'b0, 8'h07,8'h05,1'b0}, // R12 restore
    {4'd12, 8'h00,1'b0,1'b0,8'h00,1'b0,1'b0, 8'h07,8'h05,1'b1}, // R12 re-raised
    {4'd8,  8'h00,1'b0,1'b0,8'h00,1'b1,1'b0, 8'h07,8'h05,1'b0}, // R8
    {4'd6,  8'h00,1'b1,1'b1,8'h00,1'b0,1'b0, 8'h07,8'h00,1'b0}, // R6
    {4'd12, 8'h00,1'b0,1'b0,8'h00,1'b0,1'b0, 8'h07,8'h00,1'b0}, // R12
    {4'd12, 8'h00,1'b1,1'b1,8'h05,1'b0,1'b0, 8'h07,8'h05,1'b0}, // R12
    {4'd11, 8'h00,1'b0,1'b0,8'h00,1'b1,1'b0, 8'h07,8'h05,1'b1}, // R11 set wins
    {4'd8,  8'h00,1'b0,1'b0,8'h00,1'b0,1'b1, 8'h07,8'h05,1'b1}, // R8 hold
    {4'd5,  8'h01,1'b1,1'b0,8'hFE,1'b0,1'b0, 8'h07,8'h05,1'b1}, // R5 event wins
    {4'd4,  8'h00,1'b0,1'b0,8'h00,1'b0,1'b1, 8'h07,8'h05,1'b1}, // R4 tick
    {4'd3,  8'h00,1'b1,1'b0,8'h00,1'b0,1'b0, 8'h00,8'h05,1'b1}, // R3 clear all
    {4'd8,  8'h00,1'b0,1'b0,8'h00,1'b1,1'b0, 8'h00,8'h05,1'b0}, // R8
    {4'd4,  8'h08,1'b0,1'b0,8'h00,1'b0,1'b1, 8'h08,8'h05,1'b0}, // R4 event with tick
    {4'd4,  8'h00,1'b1,1'b0,8'h00,1'b0,1'b0, 8'h08,8'h05,1'b0}, // R4 still blocked
    {4'd4,  8'h00,1'b0,1'b0,8'h00,1'b0,1'b1, 8'h08,8'h05,1'b0}, // R4 tick
    {4'd3,  8'h00,1'b1,1'b0,8'h00,1'b0,1'b0, 8'h00,8'h05,1'b0}  // R3 cleared
  };

  task automatic check(input string tag, input logic [7:0] ep, input logic [7:0] em,
                       input logic ei);
    n_cmp++;
    if (pend_q !== ep || mask_q !== em || irq !== ei) begin
      n_bad++;
      $display("FAIL %s: pend=%h mask=%h irq=%b expected pend=%h mask=%h irq=%b",
               tag, pend_q, mask_q, irq, ep, em, ei);
    end
  endtask

  task automatic drive(input logic [7:0] e, input logic we, input logic sel,
                       input logic [7:0] d, input logic a, input logic t);
    evt = e; wr_en = we; wr_sel = sel; wr_data = d; ack = a; tick = t;
    @(negedge clk);
    evt = '0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; ack = 1'b0; tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 8'h00, 8'h00, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 8'h00, 8'h00, 1'b0);

    for (int k = 0; k < NV; k++) begin
      logic [40:0] v;
      v = VEC[k];
      drive(v[36:29], v[28], v[27], v[26:19], v[18], v[17]);
      check($sformatf("R%0d row %0d", v[40:37], k), v[16:9], v[8:1], v[0]);
    end

    // directed: every channel at once, full mask (R2, R7)
    drive(8'h00, 1'b1, 1'b1, 8'hFF, 1'b0, 1'b0);
    drive(8'hFF, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    check("R2 all channels", 8'hFF, 8'hFF, 1'b0);
    drive(8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
    check("R7 all channels", 8'hFF, 8'hFF, 1'b1);
    // directed: write of all ones leaves pending bits (R3)
    drive(8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
    drive(8'h00, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0);
    check("R3 ones keep", 8'hFF, 8'hFF, 1'b1);
    // directed: reset mid-run (R1)
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", 8'h00, 8'h00, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule